// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages the page pool of a network controller's packet buffer. The buffer holds up to 64 pages of 2 KB each, 128 KB in total. Every page is named by a 6-bit packet number. Transmit and receive traffic draw pages from one shared pool. A single command port lets the controller do four things: take a page, give a page back, push a packet number onto the transmit or receive queue, and pop a packet number off either queue. Both queues are hardware FIFOs of packet numbers, 64 entries deep.

Free memory and total memory are reported in 512-byte units. One page is therefore worth four units, and the full pool reports 256 units. Two interrupt conditions come from the queue state. The receive request stays high while any packet waits in the receive queue. The transmit-done request latches when the transmit queue drains to empty.

Misuse is absorbed and made visible. A full pool makes an allocation fail with a flag. A queue overrun or underrun is rejected and sets a sticky error bit for that queue. A release of a page that is already free does nothing.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset every page is free: `free_units` = 256, `total_units` = 256, both queues are empty, and `alloc_fail`, `tx_err`, `rx_err`, `rx_irq` and `tx_done_irq` are all 0.
- R2: A command with `cmd_op` = 1 (allocate) grants the lowest-numbered free page. The grant appears on `alloc_pnum` one cycle after the command, and `free_units` drops by 4 in the same cycle. `alloc_pnum` keeps the last grant until the next successful allocation.
- R3: An allocate command when no page is free sets `alloc_fail`. It leaves `free_units` and `alloc_pnum` unchanged. A later successful allocation clears `alloc_fail`.
- R4: A command with `cmd_op` = 2 (release) and `cmd_arg` naming an allocated page frees that page and raises `free_units` by 4. The page becomes eligible for the lowest-first grant again.
- R5: A release of a page that is already free is ignored, and `free_units` does not change.
- R6: Command 3 pushes `cmd_arg` onto the transmit queue, and command 4 pushes it onto the receive queue. Command 5 pops the transmit queue and command 6 pops the receive queue. Each pop places the oldest entry on `deq_pnum` one cycle later. Each queue holds 64 entries in first-in, first-out order.
- R7: A push to a full queue is rejected and leaves the queue's contents unchanged. It sets that queue's sticky error bit (`tx_err` or `rx_err`).
- R8: A pop from an empty queue is rejected, leaves `deq_pnum` unchanged, and sets that queue's sticky error bit.
- R9: `rx_irq` is 1 exactly while the receive queue holds at least one entry.
- R10: `tx_done_irq` becomes 1 in the cycle after a pop takes the last entry from the transmit queue. A later transmit push (command 3) or clear (command 7) resets it to 0.
- R11: Command 7 (clear) resets `tx_err`, `rx_err` and `tx_done_irq`, and has no other effect. Command 0 does nothing, and so does any cycle with `cmd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command code (0 none, 1 allocate, 2 release, 3 tx push, 4 rx push, 5 tx pop, 6 rx pop, 7 clear) |
| cmd_arg | input | 6 | Packet number for release and push commands |
| alloc_pnum | output | 6 | Packet number granted by the last successful allocation |
| alloc_fail | output | 1 | Last allocation found no free page |
| free_units | output | 9 | Free memory in 512-byte units |
| total_units | output | 9 | Total memory in 512-byte units |
| deq_pnum | output | 6 | Packet number returned by the last accepted pop |
| rx_irq | output | 1 | Receive queue not empty |
| tx_done_irq | output | 1 | Transmit queue has drained to empty |
| tx_err | output | 1 | Sticky transmit queue overrun or underrun |
| rx_err | output | 1 | Sticky receive queue overrun or underrun |

## Verification
Some properties are checked on every cycle by assertions. An allocation hands out a page that was marked free and lowers the count by one. An exhausted pool yields a failure. A release of a free page leaves the map untouched, and a release of a used page sets it free. A full-queue push or an empty-queue pop leaves the level alone and sets the error bit. The transmit-done request is never high while the transmit queue holds entries.

Other behaviour only the bench's scenarios can show. These are the lowest-first choice after an out-of-order release, the exact order of packet numbers through a completely filled queue, and the reset values. They also include the clearing of `alloc_fail` and `tx_done_irq` by later commands.

// File: rtl/pkt_mgr_pkg.sv
package pkt_mgr_pkg;
    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_ALLOC    = 3'd1,
        CMD_RELEASE  = 3'd2,
        CMD_TXQ_PUSH = 3'd3,
        CMD_RXQ_PUSH = 3'd4,
        CMD_TXQ_POP  = 3'd5,
        CMD_RXQ_POP  = 3'd6,
        CMD_CLEAR    = 3'd7
    } cmd_e;
endpackage

// File: rtl/pkt_page_freemap.sv
// Free-page bitmap with lowest-first grant; NUM_PAGES must equal 2**PN_W.
module pkt_page_freemap #(
    parameter int NUM_PAGES = 64,
    parameter int PN_W      = $clog2(NUM_PAGES),
    parameter int CNT_W     = $clog2(NUM_PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             rel_req,
    input  logic [PN_W-1:0]  rel_pnum,
    output logic [PN_W-1:0]  grant_pnum,
    output logic             grant_fail,
    output logic [CNT_W-1:0] free_cnt
);
    typedef struct packed {
        logic [NUM_PAGES-1:0] map;
        logic [CNT_W-1:0]     cnt;
        logic [PN_W-1:0]      pnum;
        logic                 fail;
    } fm_state_t;

    fm_state_t s_d, s_q;
    logic            low_found;
    logic [PN_W-1:0] low_idx;

    always_comb begin
        low_found = 1'b0;
        low_idx   = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (s_q.map[i]) begin
                low_found = 1'b1;
                low_idx   = PN_W'(i);
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (alloc_req) begin
            if (low_found) begin
                s_d.map[low_idx] = 1'b0;
                s_d.cnt          = s_q.cnt - CNT_W'(1);
                s_d.pnum         = low_idx;
                s_d.fail         = 1'b0;
            end else begin
                s_d.fail = 1'b1;
            end
        end else if (rel_req && !s_q.map[rel_pnum]) begin
            s_d.map[rel_pnum] = 1'b1;
            s_d.cnt           = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.map  <= '1;
            s_q.cnt  <= CNT_W'(NUM_PAGES);
            s_q.pnum <= '0;
            s_q.fail <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_pnum = s_q.pnum;
    assign grant_fail = s_q.fail;
    assign free_cnt   = s_q.cnt;

    // R2: a grant names a page that is now taken, and the count falls by one
    a_r2_grant_takes_page: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && s_q.cnt != '0 |=> !s_q.map[s_q.pnum] && !s_q.fail
                                        && (s_q.cnt + CNT_W'(1)) == $past(s_q.cnt));
    // R3: an empty pool makes the allocation fail with no change
    a_r3_exhausted_fails: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && s_q.cnt == '0 |=> s_q.fail && s_q.cnt == '0 && $stable(s_q.pnum));
    // R4: releasing a used page marks it free again
    a_r4_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        rel_req && !alloc_req && !s_q.map[rel_pnum]
        |=> s_q.map[$past(rel_pnum)] && s_q.cnt == ($past(s_q.cnt) + CNT_W'(1)));
    // R5: releasing a free page changes nothing
    a_r5_free_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        rel_req && !alloc_req && s_q.map[rel_pnum] |=> $stable(s_q.cnt) && $stable(s_q.map));
endmodule

// File: rtl/pkt_pnum_fifo.sv
// Packet-number FIFO with rejected overrun/underrun and a sticky error bit.
module pkt_pnum_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 6,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    input  logic             clr_err,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] level,
    output logic             err
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } fq_state_t;

    fq_state_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        push_ok = push && (s_q.cnt != FULL_LVL);
        pop_ok  = pop && (s_q.cnt != '0);
        s_d = s_q;
        if (push_ok) s_d.wr = (s_q.wr == LAST_PTR) ? '0 : s_q.wr + PTR_W'(1);
        if (pop_ok)  s_d.rd = (s_q.rd == LAST_PTR) ? '0 : s_q.rd + PTR_W'(1);
        if (push_ok && !pop_ok)      s_d.cnt = s_q.cnt + CNT_W'(1);
        else if (pop_ok && !push_ok) s_d.cnt = s_q.cnt - CNT_W'(1);
        if (clr_err) s_d.err = 1'b0;
        else if ((push && !push_ok) || (pop && !pop_ok)) s_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wr] <= push_data;
    end

    assign head  = mem_q[s_q.rd];
    assign level = s_q.cnt;
    assign err   = s_q.err;

    // R6: the level never exceeds the queue depth
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_LVL);
    // R7: a push into a full queue is dropped and flagged
    a_r7_full_push_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !clr_err && s_q.cnt == FULL_LVL
        |=> s_q.cnt == FULL_LVL && $stable(s_q.wr) && s_q.err);
    // R8: a pop from an empty queue is dropped and flagged
    a_r8_empty_pop_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && !clr_err && s_q.cnt == '0 |=> s_q.cnt == '0 && $stable(s_q.rd) && s_q.err);
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
    import pkt_mgr_pkg::*;
#(
    parameter int NUM_PAGES      = 64,
    parameter int QDEPTH         = 64,
    parameter int UNITS_PER_PAGE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [5:0] cmd_arg,
    output logic [5:0] alloc_pnum,
    output logic       alloc_fail,
    output logic [8:0] free_units,
    output logic [8:0] total_units,
    output logic [5:0] deq_pnum,
    output logic       rx_irq,
    output logic       tx_done_irq,
    output logic       tx_err,
    output logic       rx_err
);
    localparam int PN_W    = $clog2(NUM_PAGES);
    localparam int CNT_W   = $clog2(NUM_PAGES + 1);
    localparam int QCNT_W  = $clog2(QDEPTH + 1);
    localparam int FU_W    = 9;
    localparam logic [FU_W-1:0] TOTAL = FU_W'(NUM_PAGES * UNITS_PER_PAGE);

    typedef struct packed {
        logic [PN_W-1:0] deq;
        logic            txdone;
    } top_state_t;

    top_state_t s_d, s_q;
    cmd_e op;
    logic [PN_W-1:0]   tx_head, rx_head;
    logic [QCNT_W-1:0] tx_level, rx_level;
    logic [CNT_W-1:0]  free_cnt;
    logic do_alloc, do_rel, do_txpush, do_rxpush, do_txpop, do_rxpop, do_clr;

    always_comb begin
        op        = cmd_e'(cmd_op);
        do_alloc  = cmd_valid && op == CMD_ALLOC;
        do_rel    = cmd_valid && op == CMD_RELEASE;
        do_txpush = cmd_valid && op == CMD_TXQ_PUSH;
        do_rxpush = cmd_valid && op == CMD_RXQ_PUSH;
        do_txpop  = cmd_valid && op == CMD_TXQ_POP;
        do_rxpop  = cmd_valid && op == CMD_RXQ_POP;
        do_clr    = cmd_valid && op == CMD_CLEAR;
    end

    pkt_page_freemap #(.NUM_PAGES(NUM_PAGES)) u_freemap (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(do_alloc), .rel_req(do_rel), .rel_pnum(cmd_arg[PN_W-1:0]),
        .grant_pnum(alloc_pnum), .grant_fail(alloc_fail), .free_cnt(free_cnt)
    );

    pkt_pnum_fifo #(.DEPTH(QDEPTH), .W(PN_W)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(do_txpush), .push_data(cmd_arg[PN_W-1:0]), .pop(do_txpop), .clr_err(do_clr),
        .head(tx_head), .level(tx_level), .err(tx_err)
    );

    pkt_pnum_fifo #(.DEPTH(QDEPTH), .W(PN_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(do_rxpush), .push_data(cmd_arg[PN_W-1:0]), .pop(do_rxpop), .clr_err(do_clr),
        .head(rx_head), .level(rx_level), .err(rx_err)
    );

    always_comb begin
        s_d = s_q;
        if (do_txpop && tx_level != '0) begin
            s_d.deq = tx_head;
            if (tx_level == QCNT_W'(1)) s_d.txdone = 1'b1;
        end
        if (do_rxpop && rx_level != '0) s_d.deq = rx_head;
        if (do_txpush || do_clr) s_d.txdone = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign deq_pnum    = s_q.deq;
    assign tx_done_irq = s_q.txdone;
    assign rx_irq      = (rx_level != '0);
    assign free_units  = FU_W'(free_cnt) * FU_W'(UNITS_PER_PAGE);
    assign total_units = TOTAL;

    // R10: the transmit-done request is only ever high over an empty queue
    a_r10_txdone_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_irq |-> tx_level == '0);
    // R10: draining the last transmit entry raises the request
    a_r10_drain_raises: assert property (@(posedge clk) disable iff (!rst_n)
        do_txpop && tx_level == QCNT_W'(1) |=> tx_done_irq);
    // R11: a clear leaves no error bit behind
    a_r11_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> !tx_err && !rx_err && !tx_done_irq);
endmodule

// File: tb/pkt_page_mgr_tb.sv
module pkt_page_mgr_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [5:0] cmd_arg = 6'd0;
    logic [5:0] alloc_pnum, deq_pnum;
    logic alloc_fail, rx_irq, tx_done_irq, tx_err, rx_err;
    logic [8:0] free_units, total_units;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    pkt_page_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .alloc_pnum(alloc_pnum), .alloc_fail(alloc_fail), .free_units(free_units),
        .total_units(total_units), .deq_pnum(deq_pnum), .rx_irq(rx_irq),
        .tx_done_irq(tx_done_irq), .tx_err(tx_err), .rx_err(rx_err)
    );

    // op(3) arg(6) exp_free(9) exp_pnum(6) exp_fail(1)
    localparam int NVEC = 8;
    localparam logic [24:0] VECS [NVEC] = '{
        {3'd1, 6'd0, 9'd252, 6'd0, 1'b0},  // R2 first grant is page 0
        {3'd1, 6'd0, 9'd248, 6'd1, 1'b0},  // R2
        {3'd1, 6'd0, 9'd244, 6'd2, 1'b0},  // R2
        {3'd2, 6'd1, 9'd248, 6'd2, 1'b0},  // R4 release page 1
        {3'd2, 6'd1, 9'd248, 6'd2, 1'b0},  // R5 release again ignored
        {3'd1, 6'd0, 9'd244, 6'd1, 1'b0},  // R4 lowest free is 1 again
        {3'd2, 6'd5, 9'd244, 6'd1, 1'b0},  // R5 page 5 never allocated
        {3'd1, 6'd0, 9'd240, 6'd3, 1'b0}   // R2
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [5:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 free_units", free_units, 256);
        chk("R1 total_units", total_units, 256);
        chk("R1 flags", {alloc_fail, tx_err, rx_err, rx_irq, tx_done_irq}, 0);

        for (int i = 0; i < NVEC; i++) begin
            cmd(VECS[i][24:22], VECS[i][21:16]);
            chk($sformatf("R2/R4/R5 vec%0d free_units", i), free_units, VECS[i][15:7]);
            chk($sformatf("R2/R4/R5 vec%0d alloc_pnum", i), alloc_pnum, VECS[i][6:1]);
            chk($sformatf("R3 vec%0d alloc_fail", i), alloc_fail, VECS[i][0]);
        end

        // R11: idle and NOP cycles leave state alone
        cmd(3'd0, 6'd9);
        repeat (2) @(negedge clk);
        chk("R11 nop free_units", free_units, 240);
        chk("R11 nop alloc_pnum", alloc_pnum, 3);

        // R6 and R10: transmit order and drain
        cmd(3'd3, 6'd17);
        cmd(3'd3, 6'd42);
        chk("R10 not done while filled", tx_done_irq, 0);
        cmd(3'd5, 6'd0);
        chk("R6 tx first out", deq_pnum, 17);
        chk("R10 not done with one left", tx_done_irq, 0);
        cmd(3'd5, 6'd0);
        chk("R6 tx second out", deq_pnum, 42);
        chk("R10 done after drain", tx_done_irq, 1);
        cmd(3'd3, 6'd7);
        chk("R10 push clears done", tx_done_irq, 0);
        cmd(3'd5, 6'd0);
        chk("R10 done again", tx_done_irq, 1);
        cmd(3'd7, 6'd0);
        chk("R11 clear drops done", tx_done_irq, 0);

        // R9 and R6 on receive
        cmd(3'd4, 6'd33);
        chk("R9 rx_irq while pending", rx_irq, 1);
        cmd(3'd6, 6'd0);
        chk("R6 rx out", deq_pnum, 33);
        chk("R9 rx_irq after empty", rx_irq, 0);

        // R8 underrun on receive
        cmd(3'd6, 6'd0);
        chk("R8 rx_err set", rx_err, 1);
        chk("R8 deq unchanged", deq_pnum, 33);
        chk("R8 tx_err untouched", tx_err, 0);
        repeat (3) @(negedge clk);
        chk("R8 rx_err sticky", rx_err, 1);
        cmd(3'd7, 6'd0);
        chk("R11 clear rx_err", rx_err, 0);
        chk("R11 clear keeps pages", free_units, 240);

        // R7: fill the transmit queue, overrun, then drain in order
        do_reset();
        for (int i = 0; i < 64; i++) cmd(3'd3, 6'(i));
        chk("R7 no error at exactly full", tx_err, 0);
        cmd(3'd3, 6'd55);
        chk("R7 overrun sets tx_err", tx_err, 1);
        begin
            int bad = 0;
            for (int i = 0; i < 64; i++) begin
                cmd(3'd5, 6'd0);
                if (deq_pnum != 6'(i)) bad++;
            end
            chk("R6/R7 64-deep order intact", bad, 0);
        end
        chk("R10 done after full drain", tx_done_irq, 1);
        cmd(3'd5, 6'd0);
        chk("R8 tx underrun deq unchanged", deq_pnum, 63);

        // R3: exhaust the pool
        do_reset();
        begin
            int bad = 0;
            for (int i = 0; i < 64; i++) begin
                cmd(3'd1, 6'd0);
                if (alloc_pnum != 6'(i) || alloc_fail) bad++;
            end
            chk("R2 all 64 granted in order", bad, 0);
        end
        chk("R2 pool empty", free_units, 0);
        cmd(3'd1, 6'd0);
        chk("R3 fail flag", alloc_fail, 1);
        chk("R3 free stays 0", free_units, 0);
        chk("R3 pnum unchanged", alloc_pnum, 63);
        cmd(3'd2, 6'd37);
        chk("R4 release adds 4 units", free_units, 4);
        cmd(3'd1, 6'd0);
        chk("R4 reuse released page", alloc_pnum, 37);
        chk("R3 success clears fail", alloc_fail, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule